// File: doc/BRIEF.md
# Product-Term Sum Logic Slice

This block is one configurable sum-of-products cell. A shared input bus reaches five AND product terms. Each term has its own two-bit connection code for every bus signal. The code says whether that signal enters the term as is, enters inverted, is ignored, or forces the whole term low. A steering stage then sends each term one of two ways: into the slice's local OR gate, or out on a dedicated control line.

The OR result also takes a cascade input from the neighbouring slice. The combined value leaves on the cascade output, so slices can be chained into wider sums. A final XOR stage combines that sum with a constant low, a constant high or a chosen product term. The constants give a plain or an inverted output, and the product term allows compare and arithmetic functions.

All configuration inputs are static. The enclosing design holds them in registers and changes them only between uses. The slice itself is purely combinational.

Top module: `ptsum_slice`

## Requirements
- R1: Connection code 01 enters an input as is and code 10 enters it inverted. A product term is the AND of the contributions of all its inputs. For term t, input i, the code sits at bits [2*(t*NIN+i)+1 : 2*(t*NIN+i)] of `term_cfg`.
- R2: An input with code 00 is ignored. A term whose codes are all 00 evaluates to 1.
- R3: Any input coded 11 forces its term to 0, whatever the bus carries.
- R4: Setting bit t of `route_cfg` to 1 sends term t into the local OR. `casc_out` is the OR of all routed terms and `casc_in`. With no term routed and `casc_in` low, `casc_out` is 0.
- R5: `casc_in` high drives `casc_out` high under any configuration, so sums chain from one slice to the next.
- R6: For a term with `route_cfg` bit 0, `ctrl_out[t]` equals the term. For a term with the bit set, `ctrl_out[t]` is 0.
- R7: `pol_mode` selects the XOR stage function. 00 gives `xor_out` = sum. 01 gives the inverted sum. 10 and 11 give sum XOR term[`pol_idx`]. In those two modes, an index of NTERM or above uses 0 in place of a term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_bus | input | NIN | Shared input signals seen by every product term |
| term_cfg | input | 2*NIN*NTERM | Connection codes, two bits per input per term |
| route_cfg | input | NTERM | Per-term steering: 1 to the OR sum, 0 to the control line |
| pol_mode | input | 2 | XOR stage source selection |
| pol_idx | input | clog2(NTERM) | Product term used by the XOR stage in the term modes |
| casc_in | input | 1 | Sum arriving from the neighbouring slice |
| casc_out | output | 1 | Local OR sum including `casc_in` |
| ctrl_out | output | NTERM | Product terms used as control signals |
| xor_out | output | 1 | Result of the XOR stage |

## Verification
The embedded checks assume that every configuration input is settled before the bus is sampled. They also assume the XOR selector never holds an unknown value. The bench meets this by driving configuration and bus together on the falling clock edge and reading the outputs one nanosecond later.

Random connection codes are biased strongly toward the ignore code. This keeps a fair share of terms true and gives the OR, cascade and XOR paths both output values. Directed cases cover the all-ignored term, the forcing code, an empty OR, the cascade override and an out-of-range XOR index.

// File: rtl/ptsum_pkg.sv
// Shared encodings for the product-term sum slice.
// Assumes two-bit connection codes and a two-bit XOR source selector.
package ptsum_pkg;
    typedef enum logic [1:0] {
        CONN_OPEN = 2'b00,   // input ignored
        CONN_TRUE = 2'b01,   // input used as is
        CONN_INV  = 2'b10,   // input used inverted
        CONN_KILL = 2'b11    // term forced low
    } conn_e;

    typedef enum logic [1:0] {
        POL_PASS   = 2'b00,  // XOR with constant 0
        POL_INVERT = 2'b01,  // XOR with constant 1
        POL_TERM   = 2'b10,  // XOR with selected term
        POL_TERM2  = 2'b11   // same as POL_TERM
    } pol_e;
endpackage

// File: rtl/ptsum_term.sv
// One AND product term over the whole input bus.
// Each input has a two-bit connection code; the term is combinational.
// Assumes the configuration is static while the result is used.
module ptsum_term
    import ptsum_pkg::*;
#(
    parameter int NIN = 8
) (
    input  logic [NIN-1:0]   in_bus,
    input  logic [2*NIN-1:0] conn_cfg,
    output logic             term_out
);
    logic [NIN-1:0] lit;
    logic           kill_seen;
    logic           true_miss;

    // Contribution of each input according to its code.
    always_comb begin
        for (int i = 0; i < NIN; i++) begin
            case (conn_e'(conn_cfg[2*i +: 2]))
                CONN_OPEN: lit[i] = 1'b1;
                CONN_TRUE: lit[i] = in_bus[i];
                CONN_INV:  lit[i] = ~in_bus[i];
                default:   lit[i] = 1'b0;
            endcase
        end
    end

    // The term is the AND of every contribution.
    assign term_out = &lit;

    // Side observations used only by the checks below.
    always_comb begin
        kill_seen = 1'b0;
        true_miss = 1'b0;
        for (int i = 0; i < NIN; i++) begin
            if (conn_cfg[2*i +: 2] == 2'b11) kill_seen = 1'b1;
            if (conn_cfg[2*i +: 2] == 2'b01 && !in_bus[i]) true_miss = 1'b1;
        end
    end

    // Checks on the term against its codes.
    always_comb begin
        if (conn_cfg == '0) begin
            assert_open_term_high_R2: assert (term_out == 1'b1);
        end
        if (kill_seen) begin
            assert_kill_forces_low_R3: assert (term_out == 1'b0);
        end
        if (true_miss) begin
            assert_true_input_low_R1: assert (term_out == 1'b0);
        end
    end
endmodule

// File: rtl/ptsum_route.sv
// Steers each product term into the OR sum or out to a control line,
// and folds the cascade input into the sum.
// Assumes one steering bit per term.
module ptsum_route #(
    parameter int NTERM = 5
) (
    input  logic [NTERM-1:0] terms,
    input  logic [NTERM-1:0] route_cfg,
    input  logic             casc_in,
    output logic             sum_out,
    output logic [NTERM-1:0] ctrl_out
);
    // Build the OR sum and the control outputs.
    always_comb begin
        sum_out  = casc_in;
        ctrl_out = '0;
        for (int t = 0; t < NTERM; t++) begin
            if (route_cfg[t]) sum_out = sum_out | terms[t];
            else              ctrl_out[t] = terms[t];
        end
    end

    // Checks on the sum and the steering.
    always_comb begin
        if (casc_in) begin
            assert_casc_sets_sum_R5: assert (sum_out == 1'b1);
        end
        if (route_cfg == '0) begin
            assert_empty_or_R4: assert (sum_out == casc_in);
        end
        if ((terms & route_cfg) != '0) begin
            assert_routed_term_R4: assert (sum_out == 1'b1);
        end
        assert_ctrl_gated_R6: assert ((ctrl_out & route_cfg) == '0);
    end
endmodule

// File: rtl/ptsum_polarity.sv
// Final XOR stage: the sum XORed with a constant or a chosen product term.
// Assumes pol_idx values at or above NTERM select a constant 0.
module ptsum_polarity
    import ptsum_pkg::*;
#(
    parameter int NTERM = 5,
    parameter int IDXW  = $clog2(NTERM)
) (
    input  logic             sum_in,
    input  logic [NTERM-1:0] terms,
    input  logic [1:0]       pol_mode,
    input  logic [IDXW-1:0]  pol_idx,
    output logic             xor_out
);
    logic pick;
    logic other;

    // Pick the indexed product term, or 0 when out of range.
    always_comb begin
        pick = 1'b0;
        for (int t = 0; t < NTERM; t++) begin
            if (pol_idx == IDXW'(t)) pick = terms[t];
        end
    end

    // Choose the second XOR operand.
    always_comb begin
        case (pol_e'(pol_mode))
            POL_PASS:   other = 1'b0;
            POL_INVERT: other = 1'b1;
            default:    other = pick;
        endcase
    end

    assign xor_out = sum_in ^ other;

    // Checks on the constant modes.
    always_comb begin
        if (pol_mode == 2'b00) begin
            assert_pass_mode_R7: assert (xor_out == sum_in);
        end
        if (pol_mode == 2'b01) begin
            assert_invert_mode_R7: assert (xor_out != sum_in);
        end
    end
endmodule

// File: rtl/ptsum_slice.sv
// One product-term sum slice: NTERM product terms over a shared bus,
// steering to OR sum or control lines, cascade chaining and an XOR stage.
// Assumes all configuration inputs are held static by the enclosing design.
module ptsum_slice
    import ptsum_pkg::*;
#(
    parameter int NIN   = 8,
    parameter int NTERM = 5,
    parameter int IDXW  = $clog2(NTERM),
    parameter int TCFGW = 2 * NIN
) (
    input  logic [NIN-1:0]         in_bus,
    input  logic [TCFGW*NTERM-1:0] term_cfg,
    input  logic [NTERM-1:0]       route_cfg,
    input  logic [1:0]             pol_mode,
    input  logic [IDXW-1:0]        pol_idx,
    input  logic                   casc_in,
    output logic                   casc_out,
    output logic [NTERM-1:0]       ctrl_out,
    output logic                   xor_out
);
    logic [NTERM-1:0] terms;
    logic             sum;

    // One product term per configuration slice.
    for (genvar t = 0; t < NTERM; t++) begin : g_term
        ptsum_term #(.NIN(NIN)) i_term (
            .in_bus   (in_bus),
            .conn_cfg (term_cfg[t*TCFGW +: TCFGW]),
            .term_out (terms[t])
        );
    end

    ptsum_route #(.NTERM(NTERM)) i_route (
        .terms     (terms),
        .route_cfg (route_cfg),
        .casc_in   (casc_in),
        .sum_out   (sum),
        .ctrl_out  (ctrl_out)
    );

    ptsum_polarity #(.NTERM(NTERM), .IDXW(IDXW)) i_pol (
        .sum_in   (sum),
        .terms    (terms),
        .pol_mode (pol_mode),
        .pol_idx  (pol_idx),
        .xor_out  (xor_out)
    );

    assign casc_out = sum;
endmodule

// File: tb/test_ptsum_slice.sv
module test_ptsum_slice;
    localparam int NIN   = 8;
    localparam int NTERM = 5;
    localparam int IDXW  = $clog2(NTERM);
    localparam int TCFGW = 2 * NIN;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [NIN-1:0]         in_bus;
    logic [TCFGW*NTERM-1:0] term_cfg;
    logic [NTERM-1:0]       route_cfg;
    logic [1:0]             pol_mode;
    logic [IDXW-1:0]        pol_idx;
    logic                   casc_in;
    logic                   casc_out;
    logic [NTERM-1:0]       ctrl_out;
    logic                   xor_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    ptsum_slice #(.NIN(NIN), .NTERM(NTERM)) i_ptsum_slice (
        .in_bus(in_bus), .term_cfg(term_cfg), .route_cfg(route_cfg),
        .pol_mode(pol_mode), .pol_idx(pol_idx), .casc_in(casc_in),
        .casc_out(casc_out), .ctrl_out(ctrl_out), .xor_out(xor_out)
    );

    function automatic logic m_term(input logic [TCFGW*NTERM-1:0] cfg,
                                    input logic [NIN-1:0] bus, input int t);
        logic v = 1'b1;
        for (int i = 0; i < NIN; i++) begin
            case (cfg[t*TCFGW + 2*i +: 2])
                2'b01: v = v & bus[i];
                2'b10: v = v & ~bus[i];
                2'b11: v = 1'b0;
                default: ;
            endcase
        end
        return v;
    endfunction

    function automatic logic m_sum();
        logic s = casc_in;
        for (int t = 0; t < NTERM; t++)
            if (route_cfg[t]) s = s | m_term(term_cfg, in_bus, t);
        return s;
    endfunction

    function automatic logic [NTERM-1:0] m_ctrl();
        logic [NTERM-1:0] c = '0;
        for (int t = 0; t < NTERM; t++)
            if (!route_cfg[t]) c[t] = m_term(term_cfg, in_bus, t);
        return c;
    endfunction

    function automatic logic m_xor();
        logic o;
        case (pol_mode)
            2'b00: o = 1'b0;
            2'b01: o = 1'b1;
            default: o = (int'(pol_idx) < NTERM) ? m_term(term_cfg, in_bus, int'(pol_idx)) : 1'b0;
        endcase
        return m_sum() ^ o;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply at the falling edge, settle, then compare.
    task automatic settle();
        #1;
    endtask

    task automatic set_code(input int t, input int i, input logic [1:0] c);
        term_cfg[t*TCFGW + 2*i +: 2] = c;
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        in_bus = '0; term_cfg = '0; route_cfg = '0;
        pol_mode = 2'b00; pol_idx = '0; casc_in = 1'b0;
        settle();
        // R2: all terms fully open read as 1 on the control lines
        check("R2 open terms", 32'(ctrl_out), 32'h1f);
        // R4: empty OR with casc_in low
        check("R4 empty OR", 32'(casc_out), 0);
        check("R7 pass mode", 32'(xor_out), 0);

        // R1: true and inverted connection on input 3 of term 0
        @(negedge clk);
        set_code(0, 3, 2'b01); in_bus = 8'h00; settle();
        check("R1 true low", 32'(ctrl_out[0]), 0);
        @(negedge clk); in_bus = 8'h08; settle();
        check("R1 true high", 32'(ctrl_out[0]), 1);
        @(negedge clk); set_code(0, 3, 2'b10); settle();
        check("R1 inverted", 32'(ctrl_out[0]), 0);

        // R3: kill code on term 1 with all other inputs open
        @(negedge clk); set_code(1, 5, 2'b11); in_bus = 8'hff; settle();
        check("R3 kill", 32'(ctrl_out[1]), 0);
        @(negedge clk); in_bus = 8'h00; settle();
        check("R3 kill other bus", 32'(ctrl_out[1]), 0);

        // R4, R6: route everything to the OR
        @(negedge clk); term_cfg = '0; route_cfg = '1; settle();
        check("R4 routed sum", 32'(casc_out), 1);
        check("R6 routed ctrl low", 32'(ctrl_out), 0);

        // R5: cascade input alone
        @(negedge clk); route_cfg = '0; casc_in = 1'b1;
        for (int t = 0; t < NTERM; t++) set_code(t, 0, 2'b11);
        settle();
        check("R5 cascade passes", 32'(casc_out), 1);

        // R7: inverted mode and term modes
        @(negedge clk); casc_in = 1'b0; pol_mode = 2'b01; settle();
        check("R7 invert", 32'(xor_out), 1);
        @(negedge clk); term_cfg = '0; pol_mode = 2'b10; pol_idx = 3'd2; settle();
        check("R7 term xor", 32'(xor_out), 1);
        @(negedge clk); pol_idx = 3'd6; settle();
        check("R7 index out of range", 32'(xor_out), 0);
        @(negedge clk); pol_mode = 2'b11; pol_idx = 3'd4; route_cfg = 5'b10000; settle();
        check("R7 alt term mode", 32'(xor_out), 0);

        // R1 R4 R6 R7: random configurations against the model
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            for (int k = 0; k < NTERM*NIN; k++) begin
                int r = int'($urandom % 32);
                term_cfg[2*k +: 2] = (r < 24) ? 2'b00 : (r < 28) ? 2'b01 : (r < 31) ? 2'b10 : 2'b11;
            end
            in_bus    = NIN'($urandom);
            route_cfg = NTERM'($urandom);
            pol_mode  = 2'($urandom);
            pol_idx   = IDXW'($urandom);
            casc_in   = (($urandom % 8) == 0);
            settle();
            check("R4 random sum", 32'(casc_out), 32'(m_sum()));
            check("R6 random ctrl", 32'(ctrl_out), 32'(m_ctrl()));
            check("R7 random xor", 32'(xor_out), 32'(m_xor()));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule